// File: doc/BRIEF.md
# IPv4 Header Checksum Engine

This unit computes the one's-complement checksum of an IPv4 header held in byte-addressed, word-wide data memory. It is the execution engine behind a custom load-and-compute instruction in a small in-order processor. The host supplies the header start address and raises the select input in each cycle in which memory returns read data. The engine walks the header one 32-bit word per such cycle. It learns the header length from the first word, sums the 16-bit halfwords except the stored checksum field, folds the carries back in, and inverts the result. It then raises done for one cycle with the checksum on its output.

Control is a four-state machine. The states are `ST_FIRST` (waiting for the first header word), `ST_ACCUM` (summing the remaining words), `ST_FOLD` (folding carries) and `ST_DONE` (result presented). The transitions are:

- `ST_FIRST`→`ST_ACCUM` when the first word is taken, which latches the length.
- `ST_ACCUM`→`ST_FOLD` when the last word is taken.
- `ST_FOLD`→`ST_DONE` once no carry sits above bit 15.
- `ST_DONE`→`ST_FIRST` unconditionally on the next edge, which clears the count and the sum.

Select held low in `ST_FIRST` or `ST_ACCUM` keeps the machine where it is.

Top module: `ipv4_hdr_csum`

## Requirements
- R1: During and right after reset, done is 0, the checksum output is 0 and the read address equals the header base address.
- R2: The result is the bitwise inverse of the folded 16-bit sum of the header halfwords. It is presented zero-extended in bits 15:0 of the 32-bit output while done is high. The header 0x45000073, 0x00004000, 0x4011B861, 0xC0A80001, 0xC0A800C7 yields 0x0000B861.
- R3: The low halfword (bits 15:0) of header word index 2 is the stored checksum and never contributes to the sum.
- R4: The header length in words is bits 27:24 of word 0. It ranges from 5 to 15, and any value below 5 is treated as 5.
- R5: Exactly one header word is consumed per rising edge with select high in `ST_FIRST` or `ST_ACCUM`. With select low, the word count, the partial sum and the read address hold.
- R6: The read address equals the base address plus 4 times the number of words already consumed, so the word being consumed is always the one at the read address.
- R7: Folding repeats until nothing remains above bit 15, at one pass per cycle. If the last word is consumed at edge k and P fold passes are needed, done is high from edge k+P+1 until edge k+P+2.
- R8: Done lasts exactly one cycle. On the following edge the unit is back in `ST_FIRST` with the sum cleared, the output 0 and the read address back at the base, ready for a new header at once.
- R9: Select has no effect in `ST_FOLD` and `ST_DONE`: the read address stays at base plus 4 times the header length, and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Select, high when memory read data is valid this cycle |
| rd_data | input | 32 | Header word read from memory at `rd_addr` |
| hdr_base | input | 32 | Byte address of header word 0 |
| rd_addr | output | 32 | Byte address of the header word to consume next |
| csum | output | 32 | Checksum, zero-extended, valid while `done` is high; 0 otherwise |
| done | output | 1 | One-cycle flag marking a finished checksum |

## Verification
Every result is due at a cycle fixed by R7. The driver records the cycle counter at the edge that consumes the last word and adds the fold-pass count computed by its own reference sum. It queues the expected checksum together with that due cycle. The monitor samples done in the middle of each low clock phase and compares both the value and the cycle on which it appears. The read address is checked half a cycle before every consuming edge, during wait cycles and during folding. The return to idle is checked exactly one cycle after done.

// File: rtl/ipcs_pkg.sv
package ipcs_pkg;

    // Control states of the checksum walker
    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FOLD  = 2'd2,
        ST_DONE  = 2'd3
    } ipcs_state_e;

    // Header words are always 32 bits; halfwords are what gets summed
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

endpackage

// File: rtl/ipcs_seq.sv
module ipcs_seq
    import ipcs_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int MIN_HLEN  = 5,
    parameter int SKIP_WORD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [CNT_W-1:0] len_field,
    input  logic             carry,
    output ipcs_state_e      state,
    output logic [CNT_W-1:0] word_cnt,
    output logic             take,
    output logic             skip_lo,
    output logic             fold_en,
    output logic             done
);

    localparam logic [CNT_W-1:0] MIN_LEN  = CNT_W'(MIN_HLEN);
    localparam logic [CNT_W-1:0] SKIP_IDX = CNT_W'(SKIP_WORD);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    ipcs_state_e      state_n;
    logic [CNT_W-1:0] hlen_q;
    logic [CNT_W-1:0] hlen_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] len_clamped;
    logic             last_word;

    assign len_clamped = (len_field < MIN_LEN) ? MIN_LEN : len_field;
    assign last_word   = (word_cnt == (hlen_q - ONE));

    // State, word count and latched length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FIRST;
            word_cnt <= '0;
            hlen_q   <= MIN_LEN;
        end else begin
            state    <= state_n;
            word_cnt <= cnt_n;
            hlen_q   <= hlen_n;
        end
    end

    // Next-state selection
    always_comb begin
        state_n = state;
        cnt_n   = word_cnt;
        hlen_n  = hlen_q;
        unique case (state)
            ST_FIRST: begin
                if (sel) begin
                    hlen_n  = len_clamped;
                    cnt_n   = ONE;
                    state_n = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (sel) begin
                    cnt_n = word_cnt + ONE;
                    if (last_word) begin
                        state_n = ST_FOLD;
                    end
                end
            end
            ST_FOLD: begin
                if (!carry) begin
                    state_n = ST_DONE;
                end
            end
            ST_DONE: begin
                state_n = ST_FIRST;
                cnt_n   = '0;
                hlen_n  = MIN_LEN;
            end
            default: begin
                state_n = ST_FIRST;
            end
        endcase
    end

    // Per-state strobes for the datapath
    always_comb begin
        take    = 1'b0;
        skip_lo = 1'b0;
        fold_en = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_FIRST: take = sel;
            ST_ACCUM: begin
                take    = sel;
                skip_lo = (word_cnt == SKIP_IDX);
            end
            ST_FOLD:  fold_en = carry;
            ST_DONE:  done = 1'b1;
            default:  take = 1'b0;
        endcase
    end

    // R4: the latched length stays inside the legal range while summing
    assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM) |-> (hlen_q >= MIN_LEN))
        else $error("length below minimum");

    // R6: the count never runs past the header length
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt <= hlen_q))
        else $error("word count beyond header");

    // R5: a wait cycle keeps the count and the state
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && !sel) |=> (state == ST_ACCUM && word_cnt == $past(word_cnt)))
        else $error("count moved without select");

    // R8: the result cycle is followed by a clean idle state
    assert_done_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_FIRST && word_cnt == '0))
        else $error("no return to idle");

endmodule

// File: rtl/ipcs_accum.sv
module ipcs_accum
    import ipcs_pkg::*;
#(
    parameter int SUM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              take,
    input  logic              skip_lo,
    input  logic              fold_en,
    input  logic              clr,
    output logic [SUM_W-1:0]  sum_q,
    output logic              carry,
    output logic [HALF_W-1:0] sum_lo
);

    logic [SUM_W-1:0] word_hi;
    logic [SUM_W-1:0] word_lo;
    logic [SUM_W-1:0] folded;
    logic [SUM_W-1:0] sum_d;

    assign word_hi = SUM_W'(word_in[WORD_W-1:HALF_W]);
    assign word_lo = skip_lo ? '0 : SUM_W'(word_in[HALF_W-1:0]);
    assign folded  = SUM_W'(sum_q[HALF_W-1:0]) + SUM_W'(sum_q[SUM_W-1:HALF_W]);
    assign carry   = |sum_q[SUM_W-1:HALF_W];
    assign sum_lo  = sum_q[HALF_W-1:0];

    always_comb begin
        if (clr) begin
            sum_d = '0;
        end else if (take) begin
            sum_d = sum_q + word_hi + word_lo;
        end else if (fold_en) begin
            sum_d = folded;
        end else begin
            sum_d = sum_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    // R7: each fold pass strictly reduces the running sum
    assert_fold_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en |=> (sum_q < $past(sum_q)))
        else $error("fold did not reduce sum");

endmodule

// File: rtl/ipcs_addr.sv
module ipcs_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic [ADDR_W-1:0] hdr_base,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int BYTE_SHIFT = 2;

    assign rd_addr = hdr_base + (ADDR_W'(word_cnt) << BYTE_SHIFT);

endmodule

// File: rtl/ipv4_hdr_csum.sv
module ipv4_hdr_csum
    import ipcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SUM_W     = 32,
    parameter int CNT_W     = 4,
    parameter int MIN_HLEN  = 5,
    parameter int SKIP_WORD = 2,
    parameter int LEN_LSB   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] hdr_base,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] csum,
    output logic              done
);

    ipcs_state_e       state;
    logic [CNT_W-1:0]  word_cnt;
    logic              take;
    logic              skip_lo;
    logic              fold_en;
    logic              carry;
    logic [SUM_W-1:0]  sum_q;
    logic [HALF_W-1:0] sum_lo;
    logic [CNT_W-1:0]  len_field;

    assign len_field = rd_data[LEN_LSB +: CNT_W];

    ipcs_seq #(
        .CNT_W     (CNT_W),
        .MIN_HLEN  (MIN_HLEN),
        .SKIP_WORD (SKIP_WORD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .len_field (len_field),
        .carry     (carry),
        .state     (state),
        .word_cnt  (word_cnt),
        .take      (take),
        .skip_lo   (skip_lo),
        .fold_en   (fold_en),
        .done      (done)
    );

    ipcs_accum #(
        .SUM_W (SUM_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (rd_data),
        .take    (take),
        .skip_lo (skip_lo),
        .fold_en (fold_en),
        .clr     (done),
        .sum_q   (sum_q),
        .carry   (carry),
        .sum_lo  (sum_lo)
    );

    ipcs_addr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_addr (
        .hdr_base (hdr_base),
        .word_cnt (word_cnt),
        .rd_addr  (rd_addr)
    );

    // Result is shown only in the done cycle
    assign csum = done ? {{(WORD_W-HALF_W){1'b0}}, ~sum_lo} : '0;

    // R6: every consumed word advances the address by one word
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!$stable(hdr_base) || rd_addr == $past(rd_addr) + ADDR_W'(4)))
        else $error("address did not step by 4");

    // R5: the partial sum is frozen in a wait cycle
    assert_wait_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && !sel) |=> $stable(sum_q))
        else $error("sum changed without select");

    // R7: done is only reached once folding has finished
    assert_fold_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !carry)
        else $error("done with carry pending");

    // R8: single-cycle done, then a cleared output and sum
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && csum == '0 && sum_q == '0))
        else $error("done not a single clean pulse");

    // R9: select cannot move the address while folding
    assert_sel_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FOLD) |=> ($stable(rd_addr) || !$stable(hdr_base)))
        else $error("address moved during fold");

endmodule

// File: tb/tb_ipv4_hdr_csum.sv
`timescale 1ns/1ps
module tb_ipv4_hdr_csum;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] hdr_base = 32'h8000_2004;
    logic [31:0] rd_data;
    logic [31:0] rd_addr;
    logic [31:0] csum;
    logic        done;

    logic [31:0] mem [0:63];
    logic [31:0] wbuf [0:15];

    int cyc = 0;
    int nvec = 0;
    int nerr = 0;

    typedef struct {
        logic [31:0] cs;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    assign rd_data = mem[rd_addr[7:2]];

    ipv4_hdr_csum dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rd_data  (rd_data),
        .hdr_base (hdr_base),
        .rd_addr  (rd_addr),
        .csum     (csum),
        .done     (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Independent reference: sum, fold count and inverted result
    function automatic void ref_calc(input int hl, output logic [15:0] cs, output int p);
        logic [31:0] s;
        s = 32'h0;
        for (int i = 0; i < hl; i++) begin
            s = s + {16'h0, wbuf[i][31:16]};
            if (i != 2) s = s + {16'h0, wbuf[i][15:0]};
        end
        p = 0;
        while (s[31:16] != 16'h0) begin
            s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
            p++;
        end
        cs = ~s[15:0];
    endfunction

    // Monitor: pops the scoreboard whenever done shows up
    always @(negedge clk) begin
        #2;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8 unexpected done", csum, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(csum == e.cs, e.tag, csum, e.cs);
                chk(cyc == e.due, "R7 done cycle", 32'(cyc), 32'(e.due));
            end
        end
    end

    // Driver: loads a header, feeds words, queues the expected result
    task automatic run_hdr(input logic [31:0] base, input int gap, input bit sel_after,
                           input bit use_fix, input logic [15:0] fix_cs, input string tag);
        int nib;
        int hl;
        int p;
        logic [15:0] rc;
        bit seen;
        nib = int'(wbuf[0][27:24]);
        hl  = (nib < 5) ? 5 : nib;
        ref_calc(hl, rc, p);
        if (use_fix) rc = fix_cs;
        for (int i = 0; i < 16; i++) mem[int'(base[7:2]) + i] = wbuf[i];
        hdr_base = base;
        for (int t = 0; t < hl; t++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                sel = 1'b0;
                #1;
                chk(rd_addr == base + 32'(4 * t), "R5 wait hold", rd_addr, base + 32'(4 * t));
            end
            @(negedge clk);
            sel = 1'b1;
            #1;
            chk(rd_addr == base + 32'(4 * t), "R6 address step", rd_addr, base + 32'(4 * t));
            if (t == hl - 1) sb.push_back('{ {16'h0, rc}, cyc + p + 2, tag });
        end
        @(negedge clk);
        sel = sel_after;
        seen = 1'b0;
        for (int n = 0; n < 40 && !seen; n++) begin
            if (n > 0) @(negedge clk);
            #1;
            if (done) seen = 1'b1;
            else chk(rd_addr == base + 32'(4 * hl), "R9 address frozen", rd_addr, base + 32'(4 * hl));
        end
        if (!seen) chk(1'b0, "R7 done missing", 32'h0, 32'h1);
        @(negedge clk);
        sel = 1'b0;
        #1;
        chk(done == 1'b0, "R8 done single cycle", {31'h0, done}, 32'h0);
        chk(csum == 32'h0, "R8 output cleared", csum, 32'h0);
        chk(rd_addr == base, "R8 address back at base", rd_addr, base);
    endtask

    task automatic clear_buf();
        for (int i = 0; i < 16; i++) wbuf[i] = 32'h0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        clear_buf();
        repeat (3) @(negedge clk);
        #1;
        chk(done == 1'b0, "R1 done in reset", {31'h0, done}, 32'h0);
        chk(csum == 32'h0, "R1 csum in reset", csum, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R1 done after reset", {31'h0, done}, 32'h0);
        chk(rd_addr == hdr_base, "R1 address at base", rd_addr, hdr_base);

        // R2: worked example, one fold pass
        clear_buf();
        wbuf[0] = 32'h4500_0073; wbuf[1] = 32'h0000_4000; wbuf[2] = 32'h4011_B861;
        wbuf[3] = 32'hC0A8_0001; wbuf[4] = 32'hC0A8_00C7;
        run_hdr(32'h8000_2004, 0, 1'b0, 1'b1, 16'hB861, "R2 worked example");

        // R3: a different stored checksum must not change the result
        wbuf[2] = 32'h4011_1234;
        run_hdr(32'h8000_2004, 0, 1'b0, 1'b1, 16'hB861, "R3 checksum field skipped");

        // R4/R5: fifteen-word header with two wait cycles before each word
        clear_buf();
        wbuf[0] = 32'h4F00_003C;
        for (int i = 1; i < 15; i++) wbuf[i] = 32'(32'h1357_9BDF * (i + 1));
        wbuf[15] = 32'hFFFF_FFFF;   // beyond the header, must be ignored
        run_hdr(32'h8000_2004, 2, 1'b0, 1'b0, 16'h0, "R4 R5 fifteen words with waits");

        // R7/R9: sum 0x7FFFB folds to 0x10002 then to 0x0003; select held high
        clear_buf();
        wbuf[0] = 32'h45FF_FFFF; wbuf[1] = 32'hFFFF_FFFF; wbuf[2] = 32'hFFFF_FFFF;
        wbuf[3] = 32'hFFFF_FFFF; wbuf[4] = 32'hFFFF_BA03;
        run_hdr(32'h8000_2004, 0, 1'b1, 1'b1, 16'hFFFC, "R7 two fold passes");

        // R4: length field of 2 behaves as 5; extra words must not count
        clear_buf();
        wbuf[0] = 32'h4200_0030;
        for (int i = 1; i < 8; i++) wbuf[i] = 32'(32'h0101_0101 * i);
        run_hdr(32'h8000_2004, 1, 1'b1, 1'b0, 16'h0, "R4 short length clamped");

        // R8: new header starts right after the previous one finishes
        clear_buf();
        wbuf[0] = 32'h4500_0073; wbuf[1] = 32'h0000_4000; wbuf[2] = 32'h4011_0000;
        wbuf[3] = 32'hC0A8_0001; wbuf[4] = 32'hC0A8_00C7;
        run_hdr(32'h8000_2040, 0, 1'b0, 1'b1, 16'hB861, "R8 back to back");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R7 results outstanding", 32'(sb.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule